// File: doc/BRIEF.md
# Endpoint Packet Buffer Access Sequencer

This block lets a microprocessor and a DMA engine move 16-bit words into and out of the packet buffer of a single USB device endpoint. The processor issues an 8-bit command code with `cmd_valid`. The code either opens the endpoint buffer for reading or writing, opens the 16-bit DMA count register for one word of access, or performs a soft reset. After an endpoint command, each `cpu_wr` or `cpu_rd` pulse moves one word through a byte-addressed pointer that starts at the first byte of the buffer. A command can never move more words than the buffer holds.

The DMA path works on the same buffer through the same pointer. A 0-to-1 edge on `dma_enable` loads a private word counter from the count register. The same edge places the pointer on the second word, so the stored packet-length word is never touched. Each `dma_req` pulse then moves one word until the counter runs out. In read mode, `dma_eop` marks the final word. In write mode, the buffer is handed to the host (`buf_ready`) only when its last word has been written, or when `dma_eot` cuts the transfer short. An isochronous build (`BULK_INT = 0`) also hands the buffer over when the counter runs out.

Top module: `ep_buf_seq`

## Requirements
- R1: Codes 10h and 12h to 1Fh select a buffer read. Codes 01h to 0Fh select a buffer write. Either kind returns the pointer to byte 0. Any other code, 11h included, selects nothing: data pulses have no effect and `cpu_rdata` reads 0000h.
- R2: Each accepted word access moves the pointer by two bytes, so the k-th access after an endpoint command reaches word k of the buffer.
- R3: A command accepts at most BUF_BYTES/2 words. Writes past that limit leave the buffer unchanged. Reads past it, on either port, return 0000h.
- R4: Code F2h writes the DMA count register from one `cpu_wr`. Code F3h presents it on `cpu_rdata` for one `cpu_rd`. Further pulses under the same command are ignored, and the F3h data then reads 0000h. The register resets to 0000h.
- R5: A 0-to-1 edge on `dma_enable` sets the pointer to byte 2. DMA therefore starts at word 1, and word 0 (the packet length) is neither read nor overwritten by DMA.
- R6: During a buffer write, `buf_ready` rises in the cycle after word BUF_BYTES/2-1 is written, and not before. Any endpoint command clears it.
- R7: A `dma_eot` pulse while DMA is enabled in write mode sets `buf_ready` however full the buffer is. The same pulse stops the DMA (`dma_active` low).
- R8: In DMA read mode, `dma_eop` is high while the word on `dma_rdata` is either the last buffer word or the last word the counter allows.
- R9: The DMA edge loads the counter from the count register. Each DMA word decrements it, and `dma_active` is low whenever the counter is zero. A zero count at enable therefore moves no data.
- R10: Code F6h acts like `rst_n`. It clears the count register, the counter, `buf_ready` and the open command, and leaves the buffer contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| cpu_wr | input | 1 | Processor write pulse |
| cpu_rd | input | 1 | Processor read pulse (consumes the shown word) |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Word at the pointer, or the count register |
| dma_enable | input | 1 | DMA enable level |
| dma_req | input | 1 | DMA word pulse |
| dma_eot | input | 1 | External end of transfer pulse |
| dma_wdata | input | 16 | DMA write data |
| dma_rdata | output | 16 | DMA read data |
| dma_eop | output | 1 | Last DMA read word flag |
| dma_active | output | 1 | DMA may move a word |
| buf_ready | output | 1 | IN buffer released to the host |

## Verification
A wrong pointer shows up at once on `cpu_rdata` or `dma_rdata` as the neighbouring word, or as a spurious zero at the limit. The bench model compares every cycle, so the error is caught in the cycle it appears. A wrong counter shows up as `dma_active` or `dma_eop` changing one word early or late. A wrong release decision flips `buf_ready` in the cycle after the last write or the end-of-transfer pulse. A wrong soft reset leaves the count register readable as non-zero through F3h.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_EP_RD = 3'd1,
      ST_EP_WR = 3'd2,
      ST_CR_WR = 3'd3,
      ST_CR_RD = 3'd4
   } ebs_state_t;

   typedef struct packed {
      logic ep_rd;
      logic ep_wr;
      logic cr_wr;
      logic cr_rd;
      logic soft_rst;
   } ebs_cmd_t;

   localparam logic [7:0] CODE_CR_WR = 8'hF2;
   localparam logic [7:0] CODE_CR_RD = 8'hF3;
   localparam logic [7:0] CODE_SRST  = 8'hF6;
   localparam logic [7:0] CODE_RD_LO = 8'h12;
   localparam logic [7:0] CODE_RD_HI = 8'h1F;
   localparam logic [7:0] CODE_RD_0  = 8'h10;
   localparam logic [7:0] CODE_WR_LO = 8'h01;
   localparam logic [7:0] CODE_WR_HI = 8'h0F;

endpackage

// File: rtl/ebs_cmd_decode.sv
module ebs_cmd_decode
   import ebs_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input  logic              cmd_valid,
   input  logic [CODE_W-1:0] cmd_code,
   output ebs_cmd_t          cmd
);

   if (CODE_W != 8) begin : g_bad_code_w
      $error("ebs_cmd_decode: CODE_W must be 8");
   end

   logic is_rd, is_wr;

   always_comb begin
      is_rd = (cmd_code == CODE_RD_0) ||
              ((cmd_code >= CODE_RD_LO) && (cmd_code <= CODE_RD_HI));
      is_wr = (cmd_code >= CODE_WR_LO) && (cmd_code <= CODE_WR_HI);
      cmd.ep_rd    = cmd_valid && is_rd;
      cmd.ep_wr    = cmd_valid && is_wr;
      cmd.cr_wr    = cmd_valid && (cmd_code == CODE_CR_WR);
      cmd.cr_rd    = cmd_valid && (cmd_code == CODE_CR_RD);
      cmd.soft_rst = cmd_valid && (cmd_code == CODE_SRST);
   end

endmodule

// File: rtl/ebs_ptr.sv
module ebs_ptr #(
   parameter int BUF_BYTES = 64,
   parameter int STEP      = 2,
   localparam int WORDS    = BUF_BYTES / STEP,
   localparam int AW       = $clog2(WORDS),
   localparam int PTR_W    = AW + 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          srst,
   input  logic          rewind,
   input  logic          to_second,
   input  logic          step,
   output logic [AW-1:0] word_idx,
   output logic          in_lim
);

   if (STEP != 2) begin : g_bad_step
      $error("ebs_ptr: byte step per word must be 2");
   end

   logic [PTR_W-1:0] ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (srst || rewind)
         ptr <= '0;
      else if (to_second)
         ptr <= PTR_W'(STEP);
      else if (step && in_lim)
         ptr <= ptr + PTR_W'(STEP);
   end

   assign in_lim   = (ptr < PTR_W'(BUF_BYTES));
   assign word_idx = ptr[AW:1];

   a_r1_rewind: assert property (@(posedge clk) disable iff (!rst_n)
      (rewind && !srst) |=> (ptr == '0));

   a_r2_step_two: assert property (@(posedge clk) disable iff (!rst_n)
      (step && in_lim && !srst && !rewind && !to_second)
         |=> (ptr == $past(ptr) + PTR_W'(STEP)));

   a_r3_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= PTR_W'(BUF_BYTES));

   a_r5_skip_len: assert property (@(posedge clk) disable iff (!rst_n)
      (to_second && !srst && !rewind) |=> (word_idx == AW'(1)));

endmodule

// File: rtl/ebs_ram.sv
module ebs_ram #(
   parameter int WORDS  = 32,
   parameter int DATA_W = 16,
   localparam int AW    = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   if (WORDS < 2 || WORDS > 4096) begin : g_bad_words
      $error("ebs_ram: WORDS out of range");
   end

   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we)
         mem[addr] <= wdata;
   end

   assign rdata = mem[addr];

endmodule

// File: rtl/ebs_dma_ctl.sv
module ebs_dma_ctl #(
   parameter int CNT_W    = 16,
   parameter bit BULK_INT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic             ep_cmd,
   input  logic             ep_mode,
   input  logic             wr_mode,
   input  logic             dma_enable,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             xfer,
   input  logic             eot_hit,
   input  logic             wr_last,
   output logic             en_rise,
   output logic             live,
   output logic             active,
   output logic             cnt_last,
   output logic             buf_ready
);

   logic             en_q;
   logic [CNT_W-1:0] cnt;
   logic             extra_rel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= 1'b0;
      else if (srst)
         en_q <= 1'b0;
      else
         en_q <= dma_enable;
   end

   assign en_rise  = dma_enable && !en_q;
   assign live     = dma_enable && en_q;
   assign active   = live && ep_mode && (cnt != '0);
   assign cnt_last = (cnt == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (srst)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (eot_hit)
         cnt <= '0;
      else if (xfer)
         cnt <= cnt - CNT_W'(1);
   end

   if (BULK_INT) begin : g_bulk_rel
      assign extra_rel = 1'b0;
   end else begin : g_iso_rel
      assign extra_rel = xfer && wr_mode && cnt_last;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         buf_ready <= 1'b0;
      else if (srst || ep_cmd)
         buf_ready <= 1'b0;
      else if (wr_last || (eot_hit && wr_mode) || extra_rel)
         buf_ready <= 1'b1;
   end

   a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !srst) |=> (cnt == $past(load_val)));

   a_r9_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0) |-> !active);

   a_r9_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && !srst && !load && !eot_hit) |=> (cnt == $past(cnt) - CNT_W'(1)));

   a_r7_eot_release: assert property (@(posedge clk) disable iff (!rst_n)
      (eot_hit && wr_mode && !srst && !ep_cmd) |=> (buf_ready && !active));

   a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (!buf_ready && cnt == '0));

   a_r6_clear_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      ep_cmd |=> !buf_ready);

endmodule

// File: rtl/ep_buf_seq.sv
module ep_buf_seq
   import ebs_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int CODE_W    = 8,
   parameter int BUF_BYTES = 64,
   parameter bit BULK_INT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [CODE_W-1:0] cmd_code,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              dma_enable,
   input  logic              dma_req,
   input  logic              dma_eot,
   input  logic [DATA_W-1:0] dma_wdata,
   output logic [DATA_W-1:0] dma_rdata,
   output logic              dma_eop,
   output logic              dma_active,
   output logic              buf_ready
);

   localparam int STEP  = DATA_W / 8;
   localparam int WORDS = BUF_BYTES / STEP;
   localparam int AW    = $clog2(WORDS);

   if (DATA_W != 16) begin : g_bad_data_w
      $error("ep_buf_seq: DATA_W must be 16");
   end
   if (BUF_BYTES < 4 || (BUF_BYTES & (BUF_BYTES - 1)) != 0) begin : g_bad_buf
      $error("ep_buf_seq: BUF_BYTES must be a power of two of at least 4");
   end

   ebs_cmd_t          cmd;
   ebs_state_t        state, state_nx;
   logic              cr_done;
   logic [DATA_W-1:0] dmacr;
   logic              srst, ep_cmd;
   logic              rd_mode, wr_mode, ep_mode;
   logic              en_rise, live, act, cnt_last;
   logic              in_lim;
   logic [AW-1:0]     word_idx;
   logic [DATA_W-1:0] rd_word, ram_wdata;
   logic              load, cpu_busy, cpu_rd_ok, cpu_wr_ok;
   logic              cr_wr_ok, cr_rd_ok, eot_hit, dma_xfer;
   logic              step, we, wr_last, at_last;

   ebs_cmd_decode #(.CODE_W(CODE_W)) u_dec (
      .cmd_valid (cmd_valid),
      .cmd_code  (cmd_code),
      .cmd       (cmd)
   );

   assign srst    = cmd.soft_rst;
   assign ep_cmd  = cmd.ep_rd | cmd.ep_wr;
   assign rd_mode = (state == ST_EP_RD);
   assign wr_mode = (state == ST_EP_WR);
   assign ep_mode = rd_mode | wr_mode;

   always_comb begin
      if (cmd.ep_rd)      state_nx = ST_EP_RD;
      else if (cmd.ep_wr) state_nx = ST_EP_WR;
      else if (cmd.cr_wr) state_nx = ST_CR_WR;
      else if (cmd.cr_rd) state_nx = ST_CR_RD;
      else                state_nx = ST_IDLE;
   end

   assign cr_wr_ok = !cmd_valid && cpu_wr && (state == ST_CR_WR) && !cr_done;
   assign cr_rd_ok = !cmd_valid && cpu_rd && (state == ST_CR_RD) && !cr_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cr_done <= 1'b0;
         dmacr   <= '0;
      end else if (srst) begin
         state   <= ST_IDLE;
         cr_done <= 1'b0;
         dmacr   <= '0;
      end else if (cmd_valid) begin
         state   <= state_nx;
         cr_done <= 1'b0;
      end else if (cr_wr_ok) begin
         dmacr   <= cpu_wdata;
         cr_done <= 1'b1;
      end else if (cr_rd_ok) begin
         cr_done <= 1'b1;
      end
   end

   assign cpu_busy  = cpu_rd | cpu_wr;
   assign load      = en_rise && !cmd_valid;
   assign cpu_rd_ok = !cmd_valid && !en_rise && cpu_rd && rd_mode && in_lim;
   assign cpu_wr_ok = !cmd_valid && !en_rise && cpu_wr && wr_mode && in_lim;
   assign eot_hit   = !cmd_valid && dma_eot && live && ep_mode;
   assign dma_xfer  = !cmd_valid && !cpu_busy && !dma_eot && dma_req && act && in_lim;
   assign step      = cpu_rd_ok | cpu_wr_ok | dma_xfer;
   assign we        = cpu_wr_ok | (dma_xfer & wr_mode);
   assign ram_wdata = cpu_wr_ok ? cpu_wdata : dma_wdata;
   assign at_last   = (word_idx == AW'(WORDS - 1));
   assign wr_last   = we && at_last;

   ebs_ptr #(.BUF_BYTES(BUF_BYTES), .STEP(STEP)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .srst      (srst),
      .rewind    (ep_cmd),
      .to_second (load),
      .step      (step),
      .word_idx  (word_idx),
      .in_lim    (in_lim)
   );

   ebs_ram #(.WORDS(WORDS), .DATA_W(DATA_W)) u_ram (
      .clk   (clk),
      .we    (we),
      .addr  (word_idx),
      .wdata (ram_wdata),
      .rdata (rd_word)
   );

   ebs_dma_ctl #(.CNT_W(DATA_W), .BULK_INT(BULK_INT)) u_dma (
      .clk        (clk),
      .rst_n      (rst_n),
      .srst       (srst),
      .ep_cmd     (ep_cmd),
      .ep_mode    (ep_mode),
      .wr_mode    (wr_mode),
      .dma_enable (dma_enable),
      .load       (load),
      .load_val   (dmacr),
      .xfer       (dma_xfer),
      .eot_hit    (eot_hit),
      .wr_last    (wr_last),
      .en_rise    (en_rise),
      .live       (live),
      .active     (act),
      .cnt_last   (cnt_last),
      .buf_ready  (buf_ready)
   );

   always_comb begin
      if (rd_mode && in_lim)
         cpu_rdata = rd_word;
      else if (state == ST_CR_RD && !cr_done)
         cpu_rdata = dmacr;
      else
         cpu_rdata = '0;
   end

   assign dma_rdata  = (act && rd_mode && in_lim) ? rd_word : '0;
   assign dma_eop    = act && rd_mode && in_lim && (at_last || cnt_last);
   assign dma_active = act;

   a_r4_single_write: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CR_WR && cr_done && !cmd_valid) |=> $stable(dmacr));

   a_r3_rd_past_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_mode && !in_lim) |-> (cpu_rdata == '0 && dma_rdata == '0));

   a_r6_full_release: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr_ok && at_last) |=> buf_ready);

   a_r8_eop_only_read: assert property (@(posedge clk) disable iff (!rst_n)
      dma_eop |-> (rd_mode && dma_active));

endmodule

// File: tb/sim_ep_buf_seq.sv
`timescale 1ns/1ps
module sim_ep_buf_seq;

   localparam int NB = 64;
   localparam int NW = NB / 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [7:0]  cmd_code = '0;
   logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
   logic [15:0] cpu_wdata = '0, dma_wdata = '0;
   logic        dma_enable = 1'b0, dma_req = 1'b0, dma_eot = 1'b0;
   logic [15:0] cpu_rdata, dma_rdata;
   logic        dma_eop, dma_active, buf_ready;

   int checks = 0, errors = 0, cycles = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   ep_buf_seq #(.DATA_W(16), .CODE_W(8), .BUF_BYTES(NB), .BULK_INT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .dma_enable(dma_enable), .dma_req(dma_req), .dma_eot(dma_eot),
      .dma_wdata(dma_wdata), .dma_rdata(dma_rdata), .dma_eop(dma_eop),
      .dma_active(dma_active), .buf_ready(buf_ready)
   );

   // behavioural reference: 0 idle, 1 read, 2 write, 3 count write, 4 count read
   int m_st, m_ptr, m_cr, m_cnt, m_ready;
   bit m_done, m_enq;
   int m_mem [NW];

   function automatic int decode(input int c);
      if (c == 'h10 || (c >= 'h12 && c <= 'h1F)) return 1;
      if (c >= 'h01 && c <= 'h0F) return 2;
      if (c == 'hF2) return 3;
      if (c == 'hF3) return 4;
      return 0;
   endfunction

   function automatic bit m_active();
      return dma_enable && m_enq && m_cnt != 0 && (m_st == 1 || m_st == 2);
   endfunction

   task automatic m_reset();
      m_st = 0; m_ptr = 0; m_cr = 0; m_cnt = 0; m_ready = 0; m_done = 0; m_enq = 0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) m_reset();
      else if (cmd_valid && cmd_code == 8'hF6) m_reset();
      else begin
         bit act, inl, rise;
         int w;
         act = m_active();
         inl = m_ptr < NB;
         w = m_ptr / 2;
         rise = dma_enable && !m_enq;
         if (cmd_valid) begin
            m_st = decode(int'(cmd_code));
            m_done = 0;
            if (m_st == 1 || m_st == 2) begin m_ptr = 0; m_ready = 0; end
         end else begin
            if (rise) begin m_cnt = m_cr; m_ptr = 2; end
            if (m_st == 3 && cpu_wr && !m_done) begin m_cr = int'(cpu_wdata); m_done = 1; end
            if (m_st == 4 && cpu_rd && !m_done) m_done = 1;
            if (!rise && inl && m_st == 2 && cpu_wr) begin
               m_mem[w] = int'(cpu_wdata); m_ptr += 2;
               if (w == NW - 1) m_ready = 1;
            end else if (!rise && inl && m_st == 1 && cpu_rd) m_ptr += 2;
            if (dma_eot && dma_enable && m_enq && (m_st == 1 || m_st == 2)) begin
               m_cnt = 0;
               if (m_st == 2) m_ready = 1;
            end else if (!cpu_rd && !cpu_wr && dma_req && act && inl) begin
               if (m_st == 2) begin
                  m_mem[w] = int'(dma_wdata);
                  if (w == NW - 1) m_ready = 1;
               end
               m_ptr += 2; m_cnt -= 1;
            end
         end
         m_enq = dma_enable;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // model compared on every clock, away from the edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int ecpu, edma, eeop;
         bit inl, act;
         inl = m_ptr < NB;
         act = m_active();
         ecpu = (m_st == 1 && inl) ? m_mem[m_ptr/2] : (m_st == 4 && !m_done) ? m_cr : 0;
         edma = (act && m_st == 1 && inl) ? m_mem[m_ptr/2] : 0;
         eeop = (act && m_st == 1 && inl && (m_ptr/2 == NW - 1 || m_cnt == 1)) ? 1 : 0;
         chk("R2 model cpu_rdata", int'(cpu_rdata), ecpu);
         chk("R5 model dma_rdata", int'(dma_rdata), edma);
         chk("R8 model dma_eop", int'(dma_eop), eeop);
         chk("R9 model dma_active", int'(dma_active), int'(act));
         chk("R6 model buf_ready", int'(buf_ready), m_ready);
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000 && !done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=done", cycles);
         finish_run();
      end
   end

   task automatic cyc(); @(posedge clk); #1; endtask
   task automatic cmd(input logic [7:0] c);
      cmd_valid = 1; cmd_code = c; cyc(); cmd_valid = 0; #0.5;
   endtask
   task automatic cwr(input int d);
      cpu_wr = 1; cpu_wdata = 16'(d); cyc(); cpu_wr = 0; #0.5;
   endtask
   task automatic crd(); cpu_rd = 1; cyc(); cpu_rd = 0; #0.5; endtask
   task automatic dreq(); dma_req = 1; cyc(); dma_req = 0; #0.5; endtask
   task automatic den(); dma_enable = 1; cyc(); #0.5; endtask
   task automatic doff(); dma_enable = 0; cyc(); #0.5; endtask

   initial begin
      repeat (3) cyc();
      rst_n = 1; cyc(); #0.5;
      chk("R10 reset buf_ready", int'(buf_ready), 0);
      chk("R10 reset dma_active", int'(dma_active), 0);
      cmd(8'hF3);
      chk("R4 count reg resets to 0", int'(cpu_rdata), 0);

      cmd(8'hF2); cwr('h0005); cwr('h1234);
      cmd(8'hF3);
      chk("R4 count reg one write", int'(cpu_rdata), 'h0005);
      crd();
      chk("R4 count reg one read", int'(cpu_rdata), 0);

      cmd(8'h01);
      for (int k = 0; k < NW - 1; k++) cwr(k * 3 + 7);
      chk("R6 not ready before full", int'(buf_ready), 0);
      cwr(100);
      chk("R6 ready when full", int'(buf_ready), 1);
      cwr('hFFFF);

      cmd(8'h10);
      chk("R6 cleared by command", int'(buf_ready), 0);
      for (int k = 0; k < NW; k++) begin
         chk("R2 word sequence", int'(cpu_rdata), (k == NW - 1) ? 100 : k * 3 + 7);
         crd();
      end
      chk("R3 read past limit is zero", int'(cpu_rdata), 0);

      cmd(8'h11);
      chk("R1 code 11h selects nothing", int'(cpu_rdata), 0);
      cmd(8'h1F);
      chk("R1 code 1Fh rewinds to word 0", int'(cpu_rdata), 7);

      cmd(8'hF2); cwr(3);
      cmd(8'h12); den();
      chk("R9 active after load", int'(dma_active), 1);
      chk("R5 DMA starts at word 1", int'(dma_rdata), 10);
      chk("R8 no eop early", int'(dma_eop), 0);
      dreq();
      chk("R5 DMA word 2", int'(dma_rdata), 13);
      dreq();
      chk("R8 eop on last counted word", int'(dma_eop), 1);
      dreq();
      chk("R9 stop at zero count", int'(dma_active), 0);
      doff();

      cmd(8'hF2); cwr(40);
      cmd(8'h02); den();
      for (int k = 0; k < 4; k++) begin dma_wdata = 16'('hA000 + k); dreq(); end
      chk("R6 partial write not ready", int'(buf_ready), 0);
      dma_eot = 1; cyc(); dma_eot = 0; #0.5;
      chk("R7 eot releases buffer", int'(buf_ready), 1);
      chk("R7 eot stops DMA", int'(dma_active), 0);
      doff();
      cmd(8'h10);
      chk("R5 length word untouched", int'(cpu_rdata), 7);
      crd();
      for (int k = 0; k < 4; k++) begin
         chk("R5 DMA data in words 1-4", int'(cpu_rdata), 'hA000 + k);
         crd();
      end
      chk("R5 word 5 untouched", int'(cpu_rdata), 22);

      cmd(8'hF2); cwr(0);
      cmd(8'h10); den(); cyc();
      chk("R9 zero count no transfer", int'(dma_active), 0);
      doff();

      cmd(8'hF2); cwr(40);
      cmd(8'h10); den();
      for (int k = 0; k < NW - 2; k++) dreq();
      chk("R8 eop at last buffer word", int'(dma_eop), 1);
      chk("R8 last buffer word data", int'(dma_rdata), 100);
      dreq();
      chk("R3 DMA past limit still active", int'(dma_active), 1);
      chk("R3 DMA read past limit zero", int'(dma_rdata), 0);
      doff();

      cmd(8'hF2); cwr(9);
      cmd(8'h01);
      for (int k = 0; k < NW; k++) cwr(k + 1);
      chk("R6 ready before soft reset", int'(buf_ready), 1);
      cmd(8'hF6);
      chk("R10 soft reset clears ready", int'(buf_ready), 0);
      cmd(8'hF3);
      chk("R10 soft reset clears count reg", int'(cpu_rdata), 0);
      cmd(8'h10);
      chk("R10 buffer kept over soft reset", int'(cpu_rdata), 1);

      repeat (2) cyc();
      finish_run();
   end

endmodule